// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block watches the error pulses of a phase-frequency detector, one comparison at a time, and raises an active-high lock flag once the loop has settled. The up and down pulses are synchronised into a fast sampling clock and merged. The width of each merged pulse, counted in sampling-clock ticks, is the phase error of that comparison.

Lock is declared only after a run of consecutive comparisons whose error is below a set threshold. A precision input chooses a run length of three or five. Once lock is declared, one comparison whose error exceeds a larger clear threshold drops the flag. Errors between the two thresholds leave the flag unchanged. This gap gives the detector hysteresis, so a loop with a little jitter does not toggle the flag.

Thresholds, run lengths and synchroniser depth are parameters fixed at elaboration.

Top module: `lockdet_top`

## Requirements
- R1: While reset is asserted, and right after it is released, `lock_o` is low and the run of good comparisons is empty.
- R2: With `prec_i` = 0 and the flag low, `lock_o` rises on the third consecutive good comparison and not before it. A comparison is good when its width is strictly below `SET_TICKS`.
- R3: With `prec_i` = 1, five consecutive good comparisons are needed, and four leave `lock_o` low.
- R4: While unlocked, any comparison of width `SET_TICKS` or more empties the run, so counting restarts from zero.
- R5: While locked, a single comparison wider than `CLR_TICKS` drops `lock_o`, and a new full run is then needed to lock again.
- R6: While locked, a comparison with width from `SET_TICKS` to `CLR_TICKS` inclusive leaves `lock_o` high.
- R7: The width of a comparison is the number of sampling clocks in which `up_i` or `dn_i` is high. Overlapping up and down pulses are measured as their union.
- R8: If the merged pulse is still high after `CLR_TICKS`+1 ticks, the bad verdict is given at once, before the pulse ends. The end of that pulse gives no second verdict.
- R9: `prec_i` is read when each verdict is made. A run already at least as long as the newly selected length locks on the next good comparison.
- R10: Width `SET_TICKS`-1 is good and width `SET_TICKS` is not. Width `CLR_TICKS` does not clear lock, and width `CLR_TICKS`+1 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Up error pulse from the phase detector |
| dn_i | input | 1 | Down error pulse from the phase detector |
| prec_i | input | 1 | 0: lock after 3 good comparisons; 1: lock after 5 |
| lock_o | output | 1 | Lock flag, active high |

## Verification
Two behaviours can fall in the same cycle: the early verdict for an over-long pulse and the end of that same pulse. They could also coincide with up and down activity overlapping in one sampling clock. The bench holds a pulse well past the clear threshold and checks that the flag is low while the pulse is still high. After the pulse ends, it confirms that a normal three-comparison run is needed again. It also drives up and down pulses that overlap in time. Their union is judged by whether it resets the run, extends it, or clears lock, exactly as a single pulse of that width would.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
   typedef enum logic [1:0] {
      CLS_GOOD = 2'd0,
      CLS_MID  = 2'd1,
      CLS_BAD  = 2'd2
   } verdict_t;
endpackage

// File: rtl/lockdet_sync.sv
module lockdet_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d_i;
            else chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lockdet_width.sv
module lockdet_width
   import lockdet_pkg::*;
#(
   parameter int SET_TICKS = 6,
   parameter int CLR_TICKS = 10
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     err_i,
   output logic     strobe_o,
   output verdict_t cls_o
);
   localparam int CW = $clog2(CLR_TICKS + 2);
   localparam logic [CW-1:0] SET_V = CW'(SET_TICKS);
   localparam logic [CW-1:0] CLR_V = CW'(CLR_TICKS);
   localparam logic [CW-1:0] SAT_V = CW'(CLR_TICKS + 1);

   logic          err_q;
   logic [CW-1:0] cnt_q;
   logic          long_hit;
   logic          fall_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         err_q <= err_i;
         if (err_i && !err_q) cnt_q <= CW'(1);
         else if (err_i && cnt_q != SAT_V) cnt_q <= cnt_q + CW'(1);
      end
   end

   assign long_hit = err_i && err_q && (cnt_q == CLR_V);
   assign fall_hit = !err_i && err_q && (cnt_q <= CLR_V);
   assign strobe_o = long_hit || fall_hit;

   always_comb begin
      if (long_hit)            cls_o = CLS_BAD;
      else if (cnt_q < SET_V)  cls_o = CLS_GOOD;
      else                     cls_o = CLS_MID;
   end

   assert_single_verdict_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_o |=> !strobe_o);
   assert_long_is_bad_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_o && err_i) |-> cls_o == CLS_BAD);
   assert_cnt_bounded_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |-> cnt_q != '0);
endmodule

// File: rtl/lockdet_qual.sv
module lockdet_qual
   import lockdet_pkg::*;
#(
   parameter int NEED_LO = 3,
   parameter int NEED_HI = 5
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     strobe_i,
   input  verdict_t cls_i,
   input  logic     prec_i,
   output logic     lock_o
);
   localparam int NW = $clog2(NEED_HI + 1);

   logic [NW-1:0] run_q;
   logic [NW-1:0] need;
   logic [NW-1:0] run_inc;
   logic          lock_q;

   assign need    = prec_i ? NW'(NEED_HI) : NW'(NEED_LO);
   assign run_inc = run_q + NW'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lock_q <= 1'b0;
         run_q  <= '0;
      end else if (strobe_i) begin
         if (!lock_q) begin
            if (cls_i == CLS_GOOD) begin
               if (run_inc >= need) begin
                  lock_q <= 1'b1;
                  run_q  <= '0;
               end else begin
                  run_q <= run_inc;
               end
            end else begin
               run_q <= '0;
            end
         end else if (cls_i == CLS_BAD) begin
            lock_q <= 1'b0;
            run_q  <= '0;
         end
      end
   end

   assign lock_o = lock_q;

   assert_reset_low_R1 : assert property (@(posedge clk_i)
      !rst_ni |=> (!lock_q && run_q == '0));
   assert_rise_on_good_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_q) |-> $past(strobe_i && cls_i == CLS_GOOD));
   assert_run_reset_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_i && !lock_q && cls_i != CLS_GOOD) |=> (run_q == '0 && !lock_q));
   assert_bad_clears_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_i && lock_q && cls_i == CLS_BAD) |=> !lock_q);
   assert_mid_holds_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_i && lock_q && cls_i != CLS_BAD) |=> lock_q);
   assert_fall_on_bad_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lock_q) |-> $past(strobe_i && cls_i == CLS_BAD));
   assert_run_below_need_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q < NW'(NEED_HI));
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
   import lockdet_pkg::*;
#(
   parameter int SET_TICKS   = 6,
   parameter int CLR_TICKS   = 10,
   parameter int NEED_LO     = 3,
   parameter int NEED_HI     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic up_i,
   input  logic dn_i,
   input  logic prec_i,
   output logic lock_o
);
   generate
      if (SET_TICKS < 1)          begin : g_bad_set  $error("SET_TICKS must be at least 1"); end
      if (CLR_TICKS <= SET_TICKS) begin : g_bad_clr  $error("CLR_TICKS must exceed SET_TICKS"); end
      if (NEED_LO < 1)            begin : g_bad_lo   $error("NEED_LO must be at least 1"); end
      if (NEED_HI < NEED_LO)      begin : g_bad_hi   $error("NEED_HI must not be below NEED_LO"); end
      if (SYNC_STAGES > 4)        begin : g_bad_sync $error("SYNC_STAGES at most 4"); end
   endgenerate

   logic     up_s, dn_s, err_s;
   logic     strobe;
   verdict_t cls;

   lockdet_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(up_i), .q_o(up_s));
   lockdet_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dn_i), .q_o(dn_s));

   assign err_s = up_s | dn_s;

   lockdet_width #(.SET_TICKS(SET_TICKS), .CLR_TICKS(CLR_TICKS)) u_width (
      .clk_i(clk_i), .rst_ni(rst_ni), .err_i(err_s),
      .strobe_o(strobe), .cls_o(cls));

   lockdet_qual #(.NEED_LO(NEED_LO), .NEED_HI(NEED_HI)) u_qual (
      .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe), .cls_i(cls),
      .prec_i(prec_i), .lock_o(lock_o));
endmodule

// File: tb/lockdet_top_bench.sv
module lockdet_top_bench;
   localparam int SET_T = 6;
   localparam int CLR_T = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up = 1'b0, dn = 1'b0, prec = 1'b0;
   logic lock;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   typedef struct { bit exp; string tag; } item_t;
   item_t exp_q[$];
   event chk_ev;

   always #5 clk = ~clk;

   lockdet_top #(.SET_TICKS(SET_T), .CLR_TICKS(CLR_T)) u_lockdet_top (
      .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn),
      .prec_i(prec), .lock_o(lock));

   // monitor: compares observed lock against scoreboard entries
   initial begin
      forever begin
         @(chk_ev);
         #1;
         if (exp_q.size() != 0) begin
            item_t it;
            it = exp_q.pop_front();
            total++;
            if (lock !== it.exp) begin
               bad++;
               $display("FAIL %s: lock_o=%0b expected %0b", it.tag, lock, it.exp);
            end
         end
      end
   end

   task automatic expect_now(bit e, string tag);
      item_t it;
      it.exp = e;
      it.tag = tag;
      exp_q.push_back(it);
      -> chk_ev;
      #2;
   endtask

   task automatic gap();
      for (int i = 0; i < 8; i++) @(negedge clk);
   endtask

   task automatic pulse(int w, bit e, string tag);
      @(negedge clk);
      up = 1'b1;
      for (int i = 0; i < w; i++) @(negedge clk);
      up = 1'b0;
      gap();
      expect_now(e, tag);
   endtask

   task automatic overlap(int aw, int boff, int bw, bit e, string tag);
      int span;
      span = (aw > boff + bw) ? aw : boff + bw;
      @(negedge clk);
      for (int i = 0; i < span; i++) begin
         up = (i < aw);
         dn = (i >= boff) && (i < boff + bw);
         @(negedge clk);
      end
      up = 1'b0;
      dn = 1'b0;
      gap();
      expect_now(e, tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: lock_o=%0b expected run end", lock);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_now(1'b0, "R1 during reset");
      rst_n = 1'b1;
      gap();
      expect_now(1'b0, "R1 after reset");

      // R2: three good comparisons with prec=0
      pulse(2, 1'b0, "R2 first good");
      pulse(2, 1'b0, "R2 second good");
      pulse(2, 1'b1, "R2 third good locks");
      // R6 / R10: mid widths keep lock
      pulse(SET_T, 1'b1, "R6 R10 width SET keeps lock");
      pulse(CLR_T, 1'b1, "R10 width CLR keeps lock");
      // R5 / R10: just over clear threshold
      pulse(CLR_T + 1, 1'b0, "R5 R10 width CLR+1 clears");
      // R4 / R10: SET-1 is good, SET resets run
      pulse(SET_T - 1, 1'b0, "R10 SET-1 good 1");
      pulse(SET_T - 1, 1'b0, "R10 SET-1 good 2");
      pulse(SET_T, 1'b0, "R4 mid resets run");
      pulse(SET_T - 1, 1'b0, "R4 restart 1");
      pulse(SET_T - 1, 1'b0, "R4 restart 2");
      pulse(SET_T - 1, 1'b1, "R4 restart 3 locks");
      pulse(20, 1'b0, "R5 wide clears");
      // R3: prec=1 needs five
      prec = 1'b1;
      for (int i = 0; i < 4; i++) pulse(1, 1'b0, "R3 four not enough");
      pulse(1, 1'b1, "R3 fifth locks");
      pulse(12, 1'b0, "R5 clear after R3");
      // R9: switch precision mid-run
      for (int i = 0; i < 3; i++) pulse(1, 1'b0, "R9 run of three at prec1");
      prec = 1'b0;
      pulse(1, 1'b1, "R9 locks after switch to prec0");
      pulse(15, 1'b0, "R5 clear before R7");
      // R7: overlapping up/dn measured as union
      pulse(2, 1'b0, "R7 good 1");
      pulse(2, 1'b0, "R7 good 2");
      overlap(3, 2, 4, 1'b0, "R7 union 6 is mid, resets run");
      overlap(2, 1, 3, 1'b0, "R7 union 4 good 1");
      overlap(2, 1, 3, 1'b0, "R7 union 4 good 2");
      overlap(2, 1, 3, 1'b1, "R7 union 4 good 3 locks");
      overlap(6, 5, 6, 1'b0, "R7 union 11 clears");
      // R8: long pulse gives early verdict
      pulse(1, 1'b0, "R8 prep 1");
      pulse(1, 1'b0, "R8 prep 2");
      pulse(1, 1'b1, "R8 prep 3 locks");
      @(negedge clk);
      up = 1'b1;
      for (int i = 0; i < CLR_T + 6; i++) @(negedge clk);
      expect_now(1'b0, "R8 cleared while pulse high");
      for (int i = 0; i < 14; i++) @(negedge clk);
      up = 1'b0;
      gap();
      expect_now(1'b0, "R8 still low after pulse end");
      pulse(1, 1'b0, "R8 relock 1");
      pulse(1, 1'b0, "R8 relock 2");
      pulse(1, 1'b1, "R8 relock 3");

      gap();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule